// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers 64 interrupt request lines and presents them to a processor as two outputs: a normal interrupt and a fast interrupt. Each line is steered to one of the two outputs by its own routing bit. Each line has a 4-bit priority. A threshold register holds back normal-output lines whose priority is not above it. Two vector registers report which pending line the processor should service next. A pending line can be raised by its input pin or by a software force bit.

Software reaches the block over a simple 32-bit register bus. A single line is switched on or off by writing its number to a set-by-number or clear-by-number register, which needs no read-modify-write. Enable, routing, force, raw-input and pending state can also be read or written whole, 32 lines per word. Register reads return data one cycle after the strobe, together with a valid flag. The reset input is asserted asynchronously and released synchronously to the clock.

Top module: `vpic_top`

## Requirements
- R1: After reset, all enable, routing, force and priority bits are zero, the threshold field reads 0, both vector registers read 0xFFFFFFFF and both interrupt outputs are low.
- R2: Writing a value N from 0 to 63 to the set-by-number register (byte offset 0x08) sets only enable bit N. A written value of 64 or more changes no enable bit.
- R3: Writing a value N from 0 to 63 to the clear-by-number register (0x0C) clears only enable bit N.
- R4: Line N lives at bit N of the low word for N below 32, and at bit N-32 of the high word otherwise. The word pairs (high, low) sit at these offsets: enable 0x10/0x14, routing 0x18/0x1C, raw input 0x48/0x4C (read only), force 0x50/0x54, normal pending 0x58/0x5C, fast pending 0x60/0x64.
- R5: A line is active when it is enabled and either its input or its force bit is 1. An active line goes to fast pending when its routing bit is 1. It goes to normal pending when its routing bit is 0, subject to R8.
- R6: A force bit raises its line exactly as a high input does. A force bit on a disabled line raises nothing.
- R7: Priority word x (x = 0..7) is at offset 0x20 + 4*(7-x) and holds lines 8x..8x+7. Line 8x+k occupies bits [4k+3:4k].
- R8: The threshold is bits [4:0] of the register at 0x04. When the threshold is 31, no normal line is held back. Otherwise a normal line is pending only when its priority is greater than the threshold. Fast lines are never gated.
- R9: The normal vector (0x40) reads {line number in [31:16], priority in [15:0]} for the normal pending line with the highest priority. Ties go to the higher line number. It reads 0xFFFFFFFF when no normal line is pending.
- R10: The fast vector (0x44) reads {line number in [31:16], its priority in [15:0]} for the highest-numbered fast pending line. It reads 0xFFFFFFFF when none is pending.
- R11: The normal output is high exactly when some normal pending bit is set. The fast output is high exactly when some fast pending bit is set.
- R12: A read strobe returns data with the valid flag high one cycle later. Unmapped offsets, offset 0x00 and accesses whose address bits [1:0] are not zero read 0. Writes to read-only registers change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously and released synchronously |
| reg_sel | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 7 | Byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid when reg_rvalid is high |
| reg_rvalid | output | 1 | Read data valid, one cycle after a read strobe |
| src_in | input | 64 | Interrupt request lines, active high |
| norm_irq | output | 1 | Normal interrupt output |
| fast_irq | output | 1 | Fast interrupt output |

## Verification
The routing and pending logic is exercised with lines in both halves, steered to each output. This shows whether the half split and the routing bit are decoded separately. Force bits are applied to disabled and enabled lines, to tell forcing apart from enabling. Priority patterns cover a single winner, a tie and a winner in the top priority word, which checks the reversed word order and the tie rule. A sweep of the threshold around the line priorities shows whether the comparison is strict and whether the all-ones value lifts the gate.

// File: rtl/vpic_pkg.sv
package vpic_pkg;
  // register word indices (byte offset / 4)
  localparam logic [4:0] W_CTRL  = 5'd0;
  localparam logic [4:0] W_MASK  = 5'd1;
  localparam logic [4:0] W_ENUM  = 5'd2;
  localparam logic [4:0] W_EDIS  = 5'd3;
  localparam logic [4:0] W_ENH   = 5'd4;
  localparam logic [4:0] W_ENL   = 5'd5;
  localparam logic [4:0] W_TYH   = 5'd6;
  localparam logic [4:0] W_TYL   = 5'd7;
  localparam logic [4:0] W_PRIO0 = 5'd8;
  localparam logic [4:0] W_NVEC  = 5'd16;
  localparam logic [4:0] W_FVEC  = 5'd17;
  localparam logic [4:0] W_SRCH  = 5'd18;
  localparam logic [4:0] W_SRCL  = 5'd19;
  localparam logic [4:0] W_FRH   = 5'd20;
  localparam logic [4:0] W_FRL   = 5'd21;
  localparam logic [4:0] W_NPH   = 5'd22;
  localparam logic [4:0] W_NPL   = 5'd23;
  localparam logic [4:0] W_FPH   = 5'd24;
  localparam logic [4:0] W_FPL   = 5'd25;
endpackage

// File: rtl/vpic_regfile.sv
module vpic_regfile
  import vpic_pkg::*;
#(
  parameter int DW = 32,
  parameter int PW = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [4:0]           word,
  input  logic [DW-1:0]        wdata,
  output logic [2*DW-1:0]      en_q,
  output logic [2*DW-1:0]      typ_q,
  output logic [2*DW-1:0]      frc_q,
  output logic [2*DW*PW-1:0]   prio_q,
  output logic [PW:0]          lvl_q
);
  localparam int NSRC  = 2 * DW;
  localparam int IDW   = $clog2(NSRC);
  localparam int PER   = DW / PW;
  localparam int NPRIO = NSRC / PER;

  logic [NSRC-1:0]    en_d, typ_d, frc_d;
  logic [NSRC*PW-1:0] prio_d;
  logic [PW:0]        lvl_d;
  logic               idx_ok;

  assign idx_ok = (wdata[DW-1:IDW] == '0);

  // next-state process
  always_comb begin
    en_d   = en_q;
    typ_d  = typ_q;
    frc_d  = frc_q;
    prio_d = prio_q;
    lvl_d  = lvl_q;
    unique case (word)
      W_MASK: lvl_d = wdata[PW:0];
      W_ENUM: if (idx_ok) en_d[wdata[IDW-1:0]] = 1'b1;
      W_EDIS: if (idx_ok) en_d[wdata[IDW-1:0]] = 1'b0;
      W_ENH:  en_d[NSRC-1:DW]  = wdata;
      W_ENL:  en_d[DW-1:0]     = wdata;
      W_TYH:  typ_d[NSRC-1:DW] = wdata;
      W_TYL:  typ_d[DW-1:0]    = wdata;
      W_FRH:  frc_d[NSRC-1:DW] = wdata;
      W_FRL:  frc_d[DW-1:0]    = wdata;
      default: begin
        for (int x = 0; x < NPRIO; x++) begin
          if (word == W_PRIO0 + 5'(NPRIO - 1 - x)) prio_d[x*DW +: DW] = wdata;
        end
      end
    endcase
  end

  // register process with written-out clock enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      typ_q  <= '0;
      frc_q  <= '0;
      prio_q <= '0;
      lvl_q  <= '0;
    end else if (wr_en) begin
      en_q   <= en_d;
      typ_q  <= typ_d;
      frc_q  <= frc_d;
      prio_q <= prio_d;
      lvl_q  <= lvl_d;
    end
  end

  assert_enum_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && word == W_ENUM && idx_ok) |=> en_q[$past(wdata[IDW-1:0])]);
  assert_enum_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && word == W_ENUM) |=> ($countones(en_q ^ $past(en_q)) <= 1));
  assert_edis_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && word == W_EDIS && idx_ok) |=> !en_q[$past(wdata[IDW-1:0])]);
  assert_edis_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && word == W_EDIS) |=> ($countones(en_q ^ $past(en_q)) <= 1));
endmodule

// File: rtl/vpic_pend.sv
module vpic_pend #(
  parameter int NSRC = 64,
  parameter int PW   = 4
) (
  input  logic [NSRC-1:0]    src,
  input  logic [NSRC-1:0]    frc,
  input  logic [NSRC-1:0]    en,
  input  logic [NSRC-1:0]    typ,
  input  logic [NSRC*PW-1:0] prio,
  input  logic [PW:0]        lvl,
  output logic [NSRC-1:0]    npend,
  output logic [NSRC-1:0]    fpend
);
  logic [NSRC-1:0] active;
  logic [NSRC-1:0] pass;
  logic            gate_off;

  assign active   = (src | frc) & en;
  assign gate_off = (lvl == '1);

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    assign pass[i] = gate_off || ({1'b0, prio[i*PW +: PW]} > lvl);
  end

  assign fpend = active & typ;
  assign npend = active & ~typ & pass;
endmodule

// File: rtl/vpic_pick.sv
module vpic_pick #(
  parameter int NSRC    = 64,
  parameter int PW      = 4,
  parameter bit BY_PRIO = 1'b1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NSRC-1:0]         pend,
  input  logic [NSRC*PW-1:0]      prio,
  output logic                    found,
  output logic [$clog2(NSRC)-1:0] idx,
  output logic [PW-1:0]           pri
);
  localparam int IDW = $clog2(NSRC);

  // ascending scan: a later line wins on equal priority
  always_comb begin
    found = 1'b0;
    idx   = '0;
    pri   = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (pend[i] && (!BY_PRIO || !found || prio[i*PW +: PW] >= pri)) begin
        found = 1'b1;
        idx   = IDW'(i);
        pri   = prio[i*PW +: PW];
      end
    end
  end

  assert_pick_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> pend[idx]);
  assert_pick_any_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (pend != '0) |-> found);
endmodule

// File: rtl/vpic_top.sv
module vpic_top
  import vpic_pkg::*;
#(
  parameter int DW = 32,
  parameter int PW = 4,
  parameter int AW = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_sel,
  input  logic              reg_we,
  input  logic [AW-1:0]     reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  output logic              reg_rvalid,
  input  logic [2*DW-1:0]   src_in,
  output logic              norm_irq,
  output logic              fast_irq
);
  localparam int NSRC  = 2 * DW;
  localparam int IDW   = $clog2(NSRC);
  localparam int HW    = DW / 2;
  localparam int PER   = DW / PW;
  localparam int NPRIO = NSRC / PER;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s = rst_sync_q[1];

  logic       aligned, wr_en, rd_en;
  logic [4:0] word;
  assign aligned = (reg_addr[1:0] == 2'b00);
  assign word    = reg_addr[AW-1:2];
  assign wr_en   = reg_sel & reg_we & aligned;
  assign rd_en   = reg_sel & ~reg_we;

  logic [NSRC-1:0]    en, typ, frc, npend, fpend;
  logic [NSRC*PW-1:0] prio;
  logic [PW:0]        lvl;

  vpic_regfile #(.DW(DW), .PW(PW)) u_regs (
    .clk(clk), .rst_n(rst_s), .wr_en(wr_en), .word(word), .wdata(reg_wdata),
    .en_q(en), .typ_q(typ), .frc_q(frc), .prio_q(prio), .lvl_q(lvl)
  );

  vpic_pend #(.NSRC(NSRC), .PW(PW)) u_pend (
    .src(src_in), .frc(frc), .en(en), .typ(typ), .prio(prio), .lvl(lvl),
    .npend(npend), .fpend(fpend)
  );

  logic           n_found, f_found;
  logic [IDW-1:0] n_idx, f_idx;
  logic [PW-1:0]  n_pri, f_pri;

  vpic_pick #(.NSRC(NSRC), .PW(PW), .BY_PRIO(1'b1)) u_npick (
    .clk(clk), .rst_n(rst_s), .pend(npend), .prio(prio),
    .found(n_found), .idx(n_idx), .pri(n_pri)
  );

  vpic_pick #(.NSRC(NSRC), .PW(PW), .BY_PRIO(1'b0)) u_fpick (
    .clk(clk), .rst_n(rst_s), .pend(fpend), .prio(prio),
    .found(f_found), .idx(f_idx), .pri(f_pri)
  );

  logic [DW-1:0] nvec, fvec;
  assign nvec = n_found ? {HW'(n_idx), HW'(n_pri)} : '1;
  assign fvec = f_found ? {HW'(f_idx), HW'(f_pri)} : '1;

  assign norm_irq = |npend;
  assign fast_irq = |fpend;

  // read mux (next state) and read register
  logic [DW-1:0] rd_d;
  always_comb begin
    rd_d = '0;
    if (aligned) begin
      unique case (word)
        W_MASK: rd_d = DW'(lvl);
        W_ENH:  rd_d = en[NSRC-1:DW];
        W_ENL:  rd_d = en[DW-1:0];
        W_TYH:  rd_d = typ[NSRC-1:DW];
        W_TYL:  rd_d = typ[DW-1:0];
        W_NVEC: rd_d = nvec;
        W_FVEC: rd_d = fvec;
        W_SRCH: rd_d = src_in[NSRC-1:DW];
        W_SRCL: rd_d = src_in[DW-1:0];
        W_FRH:  rd_d = frc[NSRC-1:DW];
        W_FRL:  rd_d = frc[DW-1:0];
        W_NPH:  rd_d = npend[NSRC-1:DW];
        W_NPL:  rd_d = npend[DW-1:0];
        W_FPH:  rd_d = fpend[NSRC-1:DW];
        W_FPL:  rd_d = fpend[DW-1:0];
        default: begin
          for (int x = 0; x < NPRIO; x++) begin
            if (word == W_PRIO0 + 5'(NPRIO - 1 - x)) rd_d = prio[x*DW +: DW];
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      reg_rdata  <= '0;
      reg_rvalid <= 1'b0;
    end else begin
      reg_rvalid <= rd_en;
      if (rd_en) reg_rdata <= rd_d;
    end
  end

  assert_rvalid_rise_R12: assert property (@(posedge clk) disable iff (!rst_s)
    rd_en |=> reg_rvalid);
  assert_rvalid_idle_R12: assert property (@(posedge clk) disable iff (!rst_s)
    !rd_en |=> !reg_rvalid);
  assert_nvec_empty_R9: assert property (@(posedge clk) disable iff (!rst_s)
    !norm_irq |-> (nvec == '1));
  assert_fvec_empty_R10: assert property (@(posedge clk) disable iff (!rst_s)
    fast_irq |-> (fvec != '1));
endmodule

// File: tb/vpic_top_tb_top.sv
module vpic_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_sel, reg_we;
  logic [6:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        reg_rvalid;
  logic [63:0] src_in;
  logic        norm_irq, fast_irq;

  int checks = 0;
  int failures = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  vpic_top dut_i (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .reg_rvalid(reg_rvalid), .src_in(src_in), .norm_irq(norm_irq),
    .fast_irq(fast_irq)
  );

  // monitor: pops expected read data as the design returns it
  always @(negedge clk) begin
    if (rst_n && reg_rvalid) begin
      checks++;
      if (exp_q.size() == 0) begin
        failures++;
        $display("FAIL unexpected read data: actual %h expected none", reg_rdata);
      end else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        if (reg_rdata !== e) begin
          failures++;
          $display("FAIL %s: actual %h expected %h", t, reg_rdata, e);
        end
      end
    end
  end

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_sel = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_sel = 1'b0; reg_we = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    reg_sel = 1'b1; reg_we = 1'b0; reg_addr = a;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    reg_sel = 1'b0;
  endtask

  task automatic chk(input logic got, input logic e, input string t);
    checks++;
    if (got !== e) begin
      failures++;
      $display("FAIL %s: actual %b expected %b", t, got, e);
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_sel = 1'b0; reg_we = 1'b0; reg_addr = '0;
    reg_wdata = '0; src_in = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(7'h10, 32'h0, "R1 enable high");
    rd(7'h14, 32'h0, "R1 enable low");
    rd(7'h04, 32'h0, "R1 threshold");
    rd(7'h3C, 32'h0, "R1 priority word");
    rd(7'h40, 32'hFFFF_FFFF, "R1 normal vector");
    rd(7'h44, 32'hFFFF_FFFF, "R1 fast vector");
    chk(norm_irq, 1'b0, "R1 normal output");
    chk(fast_irq, 1'b0, "R1 fast output");

    // R2 set by number, out-of-range ignored
    wr(7'h08, 32'd5);
    wr(7'h08, 32'd40);
    rd(7'h14, 32'h0000_0020, "R2 set 5");
    rd(7'h10, 32'h0000_0100, "R2 set 40 (R4 high half)");
    wr(7'h08, 32'd64);
    rd(7'h10, 32'h0000_0100, "R2 value 64 ignored high");
    rd(7'h14, 32'h0000_0020, "R2 value 64 ignored low");

    // R3 clear by number
    wr(7'h14, 32'hFFFF_FFFF);
    wr(7'h10, 32'hFFFF_FFFF);
    wr(7'h0C, 32'd3);
    wr(7'h0C, 32'd40);
    rd(7'h14, 32'hFFFF_FFF7, "R3 clear 3");
    rd(7'h10, 32'hFFFF_FEFF, "R3 clear 40");
    wr(7'h14, 32'h0);
    wr(7'h10, 32'h0);

    // R4 R5 routing with lines in both halves
    src_in = (64'd1 << 7) | (64'd1 << 45);
    wr(7'h08, 32'd7);
    wr(7'h08, 32'd45);
    wr(7'h18, 32'h0000_2000);
    rd(7'h5C, 32'h0, "R8 prio 0 held by threshold 0");
    chk(norm_irq, 1'b0, "R8 normal output gated");
    wr(7'h04, 32'hFFFF_FFFF);
    rd(7'h04, 32'h0000_001F, "R8 threshold readback");
    rd(7'h5C, 32'h0000_0080, "R5 normal pending low");
    rd(7'h58, 32'h0, "R5 normal pending high");
    rd(7'h60, 32'h0000_2000, "R5 fast pending high");
    rd(7'h64, 32'h0, "R5 fast pending low");
    rd(7'h4C, 32'h0000_0080, "R4 raw input low");
    rd(7'h48, 32'h0000_2000, "R4 raw input high");
    chk(norm_irq, 1'b1, "R11 normal output");
    chk(fast_irq, 1'b1, "R11 fast output");
    rd(7'h40, 32'h0007_0000, "R9 single normal");
    rd(7'h44, 32'h002D_0000, "R10 single fast");

    // R6 force
    wr(7'h54, 32'h0000_0004);
    rd(7'h5C, 32'h0000_0080, "R6 force on disabled line");
    rd(7'h54, 32'h0000_0004, "R6 force readback");
    wr(7'h08, 32'd2);
    rd(7'h5C, 32'h0000_0084, "R6 force on enabled line");

    // R7 R9 priority layout and tie rule
    wr(7'h3C, 32'h3000_0900);
    rd(7'h3C, 32'h3000_0900, "R7 priority readback");
    rd(7'h40, 32'h0002_0009, "R9 highest priority wins");
    wr(7'h3C, 32'h3000_0300);
    rd(7'h40, 32'h0007_0003, "R9 tie to higher number");

    // R8 threshold sweep
    wr(7'h04, 32'd3);
    rd(7'h5C, 32'h0, "R8 equal priority blocked");
    rd(7'h40, 32'hFFFF_FFFF, "R9 empty vector under threshold");
    chk(norm_irq, 1'b0, "R11 normal output low when gated");
    rd(7'h60, 32'h0000_2000, "R8 fast not gated");
    wr(7'h04, 32'd2);
    rd(7'h5C, 32'h0000_0084, "R8 above threshold passes");

    // R7 top priority word at lowest address
    src_in[60] = 1'b1;
    wr(7'h20, 32'h000F_0000);
    wr(7'h08, 32'd60);
    rd(7'h58, 32'h1000_0000, "R4 normal pending high");
    rd(7'h40, 32'h003C_000F, "R7 word 7 at 0x20");

    // R10 fast vector ordering
    wr(7'h1C, 32'h0000_0004);
    rd(7'h64, 32'h0000_0004, "R5 forced line routed fast");
    rd(7'h44, 32'h002D_0000, "R10 highest number wins");
    wr(7'h0C, 32'd45);
    rd(7'h44, 32'h0002_0003, "R10 next fast line");

    // R11 outputs
    wr(7'h10, 32'h0);
    wr(7'h14, 32'h0000_0004);
    chk(norm_irq, 1'b0, "R11 only fast enabled normal");
    chk(fast_irq, 1'b1, "R11 only fast enabled fast");
    wr(7'h14, 32'h0);
    chk(fast_irq, 1'b0, "R11 all disabled fast");

    // R12 unmapped, read-only and misaligned
    rd(7'h68, 32'h0, "R12 unmapped");
    rd(7'h00, 32'h0, "R12 offset 0");
    wr(7'h4C, 32'h1234_5678);
    rd(7'h4C, src_in[31:0], "R12 raw input not writable");
    wr(7'h16, 32'hFFFF_FFFF);
    rd(7'h14, 32'h0, "R12 misaligned write ignored");
    rd(7'h1D, 32'h0, "R12 misaligned read zero");

    repeat (3) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      failures++;
      $display("FAIL R12 missing reads: actual %0d expected 0", exp_q.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule